// File: doc/BRIEF.md
# LCD Frame Blink and Refresh Controller

This block produces the frame-level control signals for a segment LCD driver. It sees two timing inputs: a slow reference tick, which is a single-cycle pulse at a fixed number of pulses per second, and a strobe that marks the start of each display frame. From these and two small configuration bytes it produces three signals. The first is a display-enable that implements blanking and blinking. The second is a polarity signal that can alternate from frame to frame. The third is a one-cycle strobe that copies the segment data registers into the active display buffer.

Software programs the block through a one-bit-address byte register port. The byte at address 0 holds the blink mode, the blink rate and a frame-rate divider code. The divider code is only passed out to the frame clock logic. The byte at address 1 holds three bits: an inversion enable, a refresh hold and an update-done flag. While the hold bit is set, software can rewrite the segment data without tearing the display. When the hold is released, the new data is taken at the next frame start, and that transfer raises the update-done flag.

Top module: `lcd_frame_ctl`

## Requirements
- R1: After a synchronous reset, both configuration bytes read 0, `disp_on` is 0, and `frame_inv` and `latch_stb` are 0.
- R2: Address 0 stores a whole byte: blink mode in bits 7:6, blink rate in bits 5:4 and divider code in bits 3:0. The byte reads back unchanged, and bits 3:0 appear on `frame_div` one cycle after the write. `reg_rdata` is registered and shows the byte selected by `reg_addr` in the previous cycle.
- R3: Blink mode 00 holds `disp_on` at 0, and blink mode 01 holds it at 1.
- R4: In blink mode 10, `disp_on` starts at 1 and inverts every TICKS_PER_SEC/4 ticks, which gives a 2 Hz blink.
- R5: In blink mode 11, `disp_on` starts at 1 and inverts every (rate+1)*TICKS_PER_SEC/2 ticks. Rate codes 00, 01, 10 and 11 give blink periods of 1 s, 2 s, 3 s and 4 s.
- R6: Any write to address 0 clears the tick count, and the display is on in the next cycle. If the write and a tick arrive in the same cycle, the restart wins.
- R7: At address 1, bit 0 is the inversion enable, bit 1 is the refresh hold and bit 2 is the update-done flag. Bits 7:3 read 0 and ignore writes.
- R8: While inversion is enabled, `frame_inv` inverts one cycle after each frame start. While it is disabled, `frame_inv` is 0 from the next cycle on.
- R9: A frame start seen while the hold bit is 0 produces a one-cycle `latch_stb` in the next cycle. A frame start seen while the hold bit is 1 produces none.
- R10: Every latch sets the update-done flag. A write to address 1 with bit 2 at 0 clears the flag, and a write with bit 2 at 1 leaves it unchanged. If a latch and a clear arrive in the same cycle, the latch wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference tick, TICKS_PER_SEC pulses per second |
| frame_start | input | 1 | One-cycle strobe at each frame boundary |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 1 | Register select: 0 clock/blink byte, 1 frame byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| disp_on | output | 1 | Display enable (blink output) |
| frame_inv | output | 1 | Per-frame polarity inversion |
| latch_stb | output | 1 | Copy segment data into the display buffer |
| frame_div | output | 4 | Frame-rate divider code |

## Verification
The bench goes after the blink phase at each rate boundary. A wrong period compare would flip `disp_on` one tick early or late. A missing restart would leave the display dark after a rewrite of the mode byte. The bench drives frame starts against hold changes in the same cycle. A design that sampled the new hold value would latch or miss one frame. The bench also makes the update-done flag contend with a clearing write in the same cycle, where a wrong priority drops the flag. It writes 1 to the flag and 1s to the reserved bits, which a careless decoder would treat as a clear or as storage.

// File: rtl/lcd_fc_pkg.sv
package lcd_fc_pkg;
  localparam int REG_W = 8;
  localparam int DIV_W = 4;
  localparam int RATE_W = 2;

  typedef enum logic [1:0] {
    BLK_FORCE_OFF = 2'd0,
    BLK_FORCE_ON  = 2'd1,
    BLK_FIXED     = 2'd2,
    BLK_RATED     = 2'd3
  } blink_mode_e;

  localparam logic ADDR_CLK = 1'b0;
  localparam logic ADDR_FRM = 1'b1;

  localparam int FRM_INV_BIT  = 0;
  localparam int FRM_HOLD_BIT = 1;
  localparam int FRM_DONE_BIT = 2;
endpackage

// File: rtl/lcd_fc_regs.sv
module lcd_fc_regs
  import lcd_fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              latch_now,
  output blink_mode_e       mode,
  output logic [RATE_W-1:0] rate,
  output logic [DIV_W-1:0]  div,
  output logic              inv_en,
  output logic              hold,
  output logic              done,
  output logic              restart,
  output logic [REG_W-1:0]  rdata
);
  logic [REG_W-1:0] frm_view;
  logic wr_clk, wr_frm;

  assign wr_clk  = we && (addr == ADDR_CLK);
  assign wr_frm  = we && (addr == ADDR_FRM);
  assign restart = wr_clk;

  always_comb begin
    frm_view = '0;
    frm_view[FRM_INV_BIT]  = inv_en;
    frm_view[FRM_HOLD_BIT] = hold;
    frm_view[FRM_DONE_BIT] = done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= BLK_FORCE_OFF;
      rate   <= '0;
      div    <= '0;
      inv_en <= 1'b0;
      hold   <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      rdata <= (addr == ADDR_FRM) ? frm_view : {mode, rate, div};
      if (wr_clk) begin
        mode <= blink_mode_e'(wdata[REG_W-1 -: 2]);
        rate <= wdata[DIV_W +: RATE_W];
        div  <= wdata[DIV_W-1:0];
      end
      if (wr_frm) begin
        inv_en <= wdata[FRM_INV_BIT];
        hold   <= wdata[FRM_HOLD_BIT];
      end
      if (latch_now)
        done <= 1'b1;
      else if (wr_frm && !wdata[FRM_DONE_BIT])
        done <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_fc_blink.sv
module lcd_fc_blink
  import lcd_fc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              restart,
  input  blink_mode_e       mode,
  input  logic [RATE_W-1:0] rate,
  output logic              disp_on
);
  localparam int MAX_HALF   = 2 * TICKS_PER_SEC;
  localparam int CW         = $clog2(MAX_HALF + 1);
  localparam int FIXED_HALF = TICKS_PER_SEC / 4;
  localparam int RATE_STEP  = TICKS_PER_SEC / 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          phase;

  always_comb begin
    if (mode == BLK_FIXED)
      last = CW'(FIXED_HALF - 1);
    else
      last = CW'((int'(rate) + 1) * RATE_STEP - 1);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (tick) begin
      if (cnt >= last) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (mode)
      BLK_FORCE_OFF: disp_on = 1'b0;
      BLK_FORCE_ON:  disp_on = 1'b1;
      default:       disp_on = phase;
    endcase
  end
endmodule

// File: rtl/lcd_fc_frame.sv
module lcd_fc_frame (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic inv_en,
  input  logic hold,
  output logic latch_now,
  output logic latch_stb,
  output logic frame_inv
);
  assign latch_now = frame_start && !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_stb <= 1'b0;
      frame_inv <= 1'b0;
    end else begin
      latch_stb <= latch_now;
      if (!inv_en)
        frame_inv <= 1'b0;
      else if (frame_start)
        frame_inv <= ~frame_inv;
    end
  end
endmodule

// File: rtl/lcd_frame_ctl.sv
module lcd_frame_ctl
  import lcd_fc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             frame_start,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             disp_on,
  output logic             frame_inv,
  output logic             latch_stb,
  output logic [DIV_W-1:0] frame_div
);
  blink_mode_e       blk_mode;
  logic [RATE_W-1:0] blk_rate;
  logic inv_en_q, hold_q, done_q, cfg_restart, latch_now;

  lcd_fc_regs regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .latch_now(latch_now), .mode(blk_mode), .rate(blk_rate), .div(frame_div),
    .inv_en(inv_en_q), .hold(hold_q), .done(done_q), .restart(cfg_restart),
    .rdata(reg_rdata)
  );

  lcd_fc_blink #(.TICKS_PER_SEC(TICKS_PER_SEC)) blink_i (
    .clk(clk), .rst(rst), .tick(tick), .restart(cfg_restart),
    .mode(blk_mode), .rate(blk_rate), .disp_on(disp_on)
  );

  lcd_fc_frame frame_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .inv_en(inv_en_q),
    .hold(hold_q), .latch_now(latch_now), .latch_stb(latch_stb),
    .frame_inv(frame_inv)
  );
endmodule

// File: rtl/lcd_fc_chk.sv
module lcd_fc_chk (
  input logic clk,
  input logic rst,
  input logic frame_start,
  input logic latch_stb,
  input logic frame_inv,
  input logic inv_en,
  input logic hold,
  input logic done
);
  assert_latch_cause_R9: assert property (@(posedge clk) disable iff (rst)
    latch_stb |-> ($past(frame_start) && !$past(hold)));

  assert_hold_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (frame_start && hold) |=> !latch_stb);

  assert_inv_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !inv_en |=> !frame_inv);

  assert_inv_flip_R8: assert property (@(posedge clk) disable iff (rst)
    (inv_en && frame_start) |=> (frame_inv != $past(frame_inv)));

  assert_done_on_latch_R10: assert property (@(posedge clk) disable iff (rst)
    latch_stb |-> done);
endmodule

bind lcd_frame_ctl lcd_fc_chk chk_i (
  .clk(clk), .rst(rst), .frame_start(frame_start), .latch_stb(latch_stb),
  .frame_inv(frame_inv), .inv_en(inv_en_q), .hold(hold_q), .done(done_q)
);

// File: tb/lcd_frame_ctl_tb_top.sv
`timescale 1ns/100ps
module lcd_frame_ctl_tb_top;
  localparam int TPS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, frame_start = 1'b0, reg_we = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic disp_on, frame_inv, latch_stb;
  logic [3:0] frame_div;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lcd_frame_ctl #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .frame_start(frame_start),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .disp_on(disp_on), .frame_inv(frame_inv),
    .latch_stb(latch_stb), .frame_div(frame_div)
  );

  // behavioural reference model
  logic [7:0] m_cfg = 8'h00, m_rd = 8'h00;
  bit m_inv, m_hold, m_done, m_ph = 1, m_finv, m_lat, m_rd_frm;
  int m_cnt = 0;

  function automatic int half_of(logic [7:0] cfg);
    if (cfg[7:6] == 2'd2) return TPS / 4;
    return (int'(cfg[5:4]) + 1) * TPS / 2;
  endfunction

  function automatic bit exp_disp();
    if (m_cfg[7:6] == 2'd0) return 0;
    if (m_cfg[7:6] == 2'd1) return 1;
    return m_ph;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = 0; m_rd = 0; m_inv = 0; m_hold = 0; m_done = 0;
      m_ph = 1; m_finv = 0; m_lat = 0; m_cnt = 0; m_rd_frm = 0;
    end else begin
      m_rd = reg_addr ? {5'b0, m_done, m_hold, m_inv} : m_cfg;
      m_rd_frm = reg_addr;
      m_lat = frame_start && !m_hold;
      if (!m_inv) m_finv = 0;
      else if (frame_start) m_finv = !m_finv;
      if (m_lat) m_done = 1;
      else if (reg_we && reg_addr && !reg_wdata[2]) m_done = 0;
      if (reg_we && reg_addr) begin
        m_inv = reg_wdata[0];
        m_hold = reg_wdata[1];
      end
      if (reg_we && !reg_addr) begin
        m_cfg = reg_wdata; m_cnt = 0; m_ph = 1;
      end else if (tick) begin
        m_cnt++;
        if (m_cnt >= half_of(m_cfg)) begin m_cnt = 0; m_ph = !m_ph; end
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      string dtag;
      case (m_cfg[7:6])
        2'd2: dtag = "R4";
        2'd3: dtag = "R5";
        default: dtag = "R3";
      endcase
      chk(dtag, "disp_on", disp_on, exp_disp());
      chk("R8", "frame_inv", frame_inv, m_finv);
      chk("R9", "latch_stb", latch_stb, m_lat);
      chk("R2", "frame_div", frame_div, m_cfg[3:0]);
      chk(m_rd_frm ? "R10" : "R2", "reg_rdata", reg_rdata, m_rd);
    end
  end

  task automatic step(bit t, bit fs, bit we, bit a, logic [7:0] d);
    @(negedge clk);
    #1;
    tick = t; frame_start = fs; reg_we = we; reg_addr = a; reg_wdata = d;
  endtask

  task automatic idle(bit a);
    step(0, 0, 0, a, 8'h00);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    idle(0);
    chk("R1", "rdata after reset", reg_rdata, 0);
    chk("R1", "disp_on after reset", disp_on, 0);
    chk("R1", "frame_inv after reset", frame_inv, 0);
    idle(1); idle(1);
    chk("R1", "frame byte after reset", reg_rdata, 0);

    // R3 forced on
    step(0, 0, 1, 0, 8'h45); idle(0);
    chk("R3", "mode 01 disp_on", disp_on, 1);
    chk("R2", "frame_div", frame_div, 4'h5);

    // R4 fixed 2 Hz: flips every tick with TPS=4
    step(0, 0, 1, 0, 8'h80); idle(0);
    chk("R4", "mode 10 start", disp_on, 1);
    step(1, 0, 0, 0, 8'h00); idle(0);
    chk("R4", "mode 10 after 1 tick", disp_on, 0);

    // R5 / R6: rate 3 -> 8 ticks per half
    step(0, 0, 1, 0, 8'hF0);
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 8'h00);
    idle(0);
    chk("R5", "rate 3 after 7 ticks", disp_on, 1);
    step(1, 0, 0, 0, 8'h00); idle(0);
    chk("R5", "rate 3 after 8 ticks", disp_on, 0);
    step(1, 0, 1, 0, 8'hF0); idle(0);
    chk("R6", "restart beats tick", disp_on, 1);

    // R7 reserved bits
    step(0, 0, 1, 1, 8'hF8); idle(1); idle(1);
    chk("R7", "reserved bits", int'(reg_rdata[7:3]), 0);

    // R9 hold blocks latch
    step(0, 0, 1, 1, 8'h02);
    step(0, 1, 0, 1, 8'h00); idle(1);
    chk("R9", "no latch while held", latch_stb, 0);
    step(0, 0, 1, 1, 8'h00);
    step(0, 1, 0, 1, 8'h00); idle(1);
    chk("R9", "latch after release", latch_stb, 1);
    idle(1);
    chk("R10", "done set", int'(reg_rdata[2]), 1);
    step(0, 0, 1, 1, 8'h04); idle(1); idle(1);
    chk("R10", "write 1 keeps done", int'(reg_rdata[2]), 1);
    step(0, 0, 1, 1, 8'h00); idle(1); idle(1);
    chk("R10", "write 0 clears done", int'(reg_rdata[2]), 0);
    step(0, 1, 1, 1, 8'h00); idle(1); idle(1);
    chk("R10", "latch wins over clear", int'(reg_rdata[2]), 1);

    // R8 inversion
    step(0, 0, 1, 1, 8'h01);
    step(0, 1, 0, 1, 8'h00); idle(1);
    chk("R8", "first inverted frame", frame_inv, 1);
    step(0, 1, 0, 1, 8'h00); idle(1);
    chk("R8", "second frame", frame_inv, 0);

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++)
      step($urandom % 2, ($urandom % 8) == 0, ($urandom % 30) == 0,
           $urandom % 2, 8'($urandom));
    idle(0); idle(0);

    finished = 1;
    summary();
    $finish;
  end
endmodule